// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is an 18-kilobit storage array (16 kilobits of data plus 2 kilobits of parity) with one write port and one read port. The read port always returns a full row: 32 data bits and 4 parity bits. The write port is narrow, and its width is fixed at elaboration by the `NARROW_W` parameter to 1, 2, 4, 9, 18 or 36 bits. A narrow write replaces one slice of a row. The remaining bits of that row keep their contents.

Both ports take a 14-bit byte-style address. The upper nine bits pick one of 512 rows. On the write side, the bits below bit 5 that remain active at the chosen width pick the slice, with the least significant slice first. Any lower bits are ignored. Widths of 9 and above carry 1, 2 or 4 parity bits next to 8, 16 or 32 data bits. Those parity bits sit in a parity lane of the row that matches the slice. Widths of 1, 2 and 4 have no parity.

The read is synchronous and has one cycle of latency. A read that lands in the same cycle as a write to the same row returns the contents from before the write.

Top module: `mixw_sdp_ram`

## Requirements
- R1: The row is taken from address bits 13 to 5 on both ports. Read address bits 4 to 0 have no effect on the returned row.
- R2: With `NARROW_W` in {1,2,4}, a write carries `NARROW_W` data bits and no parity. With `NARROW_W` in {9,18,36}, a write carries `NARROW_W/9*8` data bits and `NARROW_W/9` parity bits.
- R3: Let D be the data width and L = log2(D). A write with `wr_en`=1 replaces row bits `[s*D +: D]` of `rd_data`, where s = `wr_addr[4:L]`. `wr_addr` bits below L are ignored. All other data bits of the row are unchanged.
- R4: For widths of 9 and above, with P parity bits, the write places `wr_par` in bits `[s*P +: P]` of `rd_par`. The other parity bits are unchanged.
- R5: For widths below 9, `wr_par` is ignored and `rd_par` always reads 0.
- R6: When `rd_en`=1 at a rising edge, `rd_data` and `rd_par` show the addressed row after that same edge.
- R7: When `rd_en`=0 at a rising edge, `rd_data` and `rd_par` keep their values, even if a write occurs.
- R8: A read and a write to the same row at the same edge return the row as it was before the write. The new contents are visible to the next read.
- R9: While the reset is asserted and after it is released, `rd_data` and `rd_par` are 0 until the first read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 14 | Write address; bits 13..5 select the row, the upper low bits select the slice |
| wr_data | input | NARROW_W data bits (1,2,4,8,16,32) | Write data slice |
| wr_par | input | max(1, NARROW_W/9) | Write parity slice; unused below width 9 |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 14 | Read address; bits 13..5 select the row |
| rd_data | output | 32 | Registered row data |
| rd_par | output | 4 | Registered row parity |

## Verification
Two instances, one with width 9 and one with width 4, receive the same stimulus. One instance has parity lanes and byte slices. The other has no parity and nibble slices, so a fault in lane placement or in parity suppression shows up in one of them. The test first writes every address in ascending order and reads back every row with random low read-address bits. This separates correct slice decoding from aliasing between rows and from sensitivity to the ignored address bits. Directed cases then cover garbage in the ignored write-address bits, a read and a write to the same row in one cycle (old data against new data), and a write while reads are disabled (hold against spurious update). Thousands of random cycles follow, with forced row collisions.

// File: rtl/mwsdp_pkg.sv
package mwsdp_pkg;
  localparam int ADDR_W  = 14;
  localparam int ROW_DW  = 32;
  localparam int ROW_PW  = 4;
  localparam int ROW_W   = ROW_DW + ROW_PW;
  localparam int ROWS    = 512;
  localparam int ROW_AW  = $clog2(ROWS);
  localparam int LANE_AW = ADDR_W - ROW_AW;

  function automatic int data_bits(input int w);
    return (w >= 9) ? (w / 9) * 8 : w;
  endfunction

  function automatic int par_bits(input int w);
    return (w >= 9) ? (w / 9) : 0;
  endfunction
endpackage

// File: rtl/mwsdp_rst_sync.sv
module mwsdp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/mwsdp_addr_split.sv
module mwsdp_addr_split
  import mwsdp_pkg::*;
#(
  parameter int LSB = 3
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [ROW_AW-1:0]  row,
  output logic [LANE_AW-1:0] bitoff
);
  localparam logic [LANE_AW-1:0] LOW_MASK = LANE_AW'((1 << LSB) - 1);

  always_comb begin
    row    = addr[ADDR_W-1:LANE_AW];
    bitoff = addr[LANE_AW-1:0] & ~LOW_MASK;
  end
endmodule

// File: rtl/mwsdp_wr_lanes.sv
module mwsdp_wr_lanes
  import mwsdp_pkg::*;
#(
  parameter int NDW = 8,
  parameter int NP  = 1,
  parameter int NPW = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [LANE_AW-1:0] bitoff,
  input  logic [NDW-1:0]     din,
  input  logic [NPW-1:0]     pin,
  output logic [ROW_W-1:0]   mask,
  output logic [ROW_W-1:0]   val
);
  logic [63:0] dmask_w;
  logic [63:0] dval_w;

  always_comb begin
    dmask_w = {{(64-NDW){1'b0}}, {NDW{1'b1}}} << bitoff;
    dval_w  = {{(64-NDW){1'b0}}, din} << bitoff;
  end

  assign mask[ROW_DW-1:0] = dmask_w[ROW_DW-1:0];
  assign val[ROW_DW-1:0]  = dval_w[ROW_DW-1:0];

  logic lanes_unused;
  assign lanes_unused = ^{dmask_w[63:ROW_DW], dval_w[63:ROW_DW]};

  generate
    if (NP > 0) begin : g_par
      logic [2:0] pidx;
      logic [7:0] pmask_w;
      logic [7:0] pval_w;
      always_comb begin
        pidx    = 3'(bitoff >> 3);
        pmask_w = {{(8-NP){1'b0}}, {NP{1'b1}}} << pidx;
        pval_w  = {{(8-NP){1'b0}}, pin} << pidx;
      end
      assign mask[ROW_W-1:ROW_DW] = pmask_w[ROW_PW-1:0];
      assign val[ROW_W-1:ROW_DW]  = pval_w[ROW_PW-1:0];
      logic par_unused;
      assign par_unused = ^{pmask_w[7:ROW_PW], pval_w[7:ROW_PW]};

      AST_PAR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ($countones(mask[ROW_W-1:ROW_DW]) == NP)); // R4
    end else begin : g_nopar
      assign mask[ROW_W-1:ROW_DW] = '0;
      assign val[ROW_W-1:ROW_DW]  = '0;
      logic pin_unused;
      assign pin_unused = ^pin;
    end
  endgenerate

  AST_LANE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(mask[ROW_DW-1:0]) == NDW)); // R3
  AST_VAL_IN_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((val & ~mask) == '0)); // R3
  AST_OFF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((int'(bitoff) % NDW) == 0)); // R3
endmodule

// File: rtl/mwsdp_store.sv
module mwsdp_store
  import mwsdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ROW_AW-1:0] wrow,
  input  logic [ROW_W-1:0]  wmask,
  input  logic [ROW_W-1:0]  wval,
  input  logic              re,
  input  logic [ROW_AW-1:0] rrow,
  output logic [ROW_W-1:0]  rq
);
  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] rq_d;

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < ROW_W; b++) begin
        if (wmask[b]) begin
          mem[wrow][b] <= wval[b];
        end
      end
    end
  end

  always_comb begin
    rq_d = re ? mem[rrow] : rq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq <= '0;
    end else begin
      rq <= rq_d;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rq)); // R7
endmodule

// File: rtl/mixw_sdp_ram.sv
module mixw_sdp_ram
  import mwsdp_pkg::*;
#(
  parameter  int NARROW_W = 9,
  localparam int NDW      = data_bits(NARROW_W),
  localparam int NP       = par_bits(NARROW_W),
  localparam int NPW      = (NP > 0) ? NP : 1,
  localparam int LSB      = $clog2(NDW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NDW-1:0]    wr_data,
  input  logic [NPW-1:0]    wr_par,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ROW_DW-1:0] rd_data,
  output logic [ROW_PW-1:0] rd_par
);
  logic               rst_n_s;
  logic [ROW_AW-1:0]  wr_row;
  logic [LANE_AW-1:0] wr_off;
  logic [ROW_AW-1:0]  rd_row;
  logic [LANE_AW-1:0] rd_off_unused;
  logic [ROW_W-1:0]   lane_mask;
  logic [ROW_W-1:0]   lane_val;
  logic [ROW_W-1:0]   row_q;

  mwsdp_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  mwsdp_addr_split #(.LSB(LSB)) u_wsplit (
    .addr   (wr_addr),
    .row    (wr_row),
    .bitoff (wr_off)
  );

  mwsdp_addr_split #(.LSB(LANE_AW)) u_rsplit (
    .addr   (rd_addr),
    .row    (rd_row),
    .bitoff (rd_off_unused)
  );

  mwsdp_wr_lanes #(.NDW(NDW), .NP(NP), .NPW(NPW)) u_lanes (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .en     (wr_en),
    .bitoff (wr_off),
    .din    (wr_data),
    .pin    (wr_par),
    .mask   (lane_mask),
    .val    (lane_val)
  );

  mwsdp_store u_store (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (wr_en),
    .wrow  (wr_row),
    .wmask (lane_mask),
    .wval  (lane_val),
    .re    (rd_en),
    .rrow  (rd_row),
    .rq    (row_q)
  );

  assign rd_data = row_q[ROW_DW-1:0];

  generate
    if (NP > 0) begin : g_rpar
      assign rd_par = row_q[ROW_W-1:ROW_DW];
    end else begin : g_rnopar
      assign rd_par = '0;
      logic rpar_unused;
      assign rpar_unused = ^row_q[ROW_W-1:ROW_DW];
    end
  endgenerate
endmodule

// File: tb/tb_mixw_sdp_ram.sv
module tb_mixw_sdp_ram;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [13:0] wr_addr;
  logic [31:0] wd;
  logic [3:0]  wp;
  logic        rd_en;
  logic [13:0] rd_addr;
  logic [31:0] rd_data9, rd_data4;
  logic [3:0]  rd_par9, rd_par4;

  int n_tests = 0;
  int n_fail  = 0;

  logic [35:0] mod9 [512];
  logic [35:0] mod4 [512];
  logic [35:0] exp9 = '0;
  logic [35:0] exp4 = '0;

  always #2 clk = ~clk;

  mixw_sdp_ram #(.NARROW_W(9)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wd[7:0]), .wr_par(wp[0:0]), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data9), .rd_par(rd_par9)
  );

  mixw_sdp_ram #(.NARROW_W(4)) dut_n4 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wd[3:0]), .wr_par(wp[0:0]), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data4), .rd_par(rd_par4)
  );

  function automatic logic [35:0] apply(input logic [35:0] word, input int nw,
                                        input logic [13:0] a, input logic [31:0] d,
                                        input logic [3:0] p);
    int ndw = (nw >= 9) ? (nw / 9) * 8 : nw;
    int np  = (nw >= 9) ? (nw / 9) : 0;
    int s   = int'(a[4:0]) / ndw;
    for (int i = 0; i < ndw; i++) word[s*ndw + i] = d[i];
    for (int i = 0; i < np; i++) word[32 + s*np + i] = p[i];
    return word;
  endfunction

  task automatic chk(input string tag, input logic [35:0] got, input logic [35:0] expv);
    n_tests++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, expv);
    end
  endtask

  task automatic step(input logic we, input logic [13:0] wa, input logic [31:0] wdi,
                      input logic [3:0] wpi, input logic re, input logic [13:0] ra,
                      input string tag);
    wr_en = we; wr_addr = wa; wd = wdi; wp = wpi; rd_en = re; rd_addr = ra;
    if (re) begin
      exp9 = mod9[ra[13:5]];
      exp4 = mod4[ra[13:5]];
    end
    if (we) begin
      mod9[wa[13:5]] = apply(mod9[wa[13:5]], 9, wa, wdi, wpi);
      mod4[wa[13:5]] = apply(mod4[wa[13:5]], 4, wa, wdi, wpi);
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " data w9"}, {4'h0, rd_data9}, {4'h0, exp9[31:0]});
    chk("R4 parity w9", {32'h0, rd_par9}, {32'h0, exp9[35:32]});
    chk({tag, " data w4"}, {4'h0, rd_data4}, {4'h0, exp4[31:0]});
    chk("R5 parity w4", {32'h0, rd_par4}, 36'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int r = 0; r < 512; r++) begin
      mod9[r] = '0;
      mod4[r] = '0;
    end
    rst_n = 1'b0; wr_en = 0; wr_addr = '0; wd = '0; wp = '0; rd_en = 0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset w9", {rd_par9, rd_data9}, 36'h0);
    chk("R9 reset w4", {rd_par4, rd_data4}, 36'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 after release w9", {rd_par9, rd_data9}, 36'h0);
    chk("R9 after release w4", {rd_par4, rd_data4}, 36'h0);

    // Fill every address; reads disabled, outputs must hold zero
    for (int a = 0; a < 16384; a++) step(1'b1, 14'(a), $urandom, 4'($urandom), 1'b0, '0, "R2");

    // Read back all rows with random ignored low read-address bits
    for (int r = 0; r < 512; r++) step(1'b0, '0, '0, '0, 1'b1, {9'(r), 5'($urandom)}, "R1");

    // Ignored low write-address bits
    step(1'b1, {9'd7, 5'b11101}, 32'h0000_00A5, 4'hF, 1'b0, '0, "R3");
    step(1'b0, '0, '0, '0, 1'b1, {9'd7, 5'd0}, "R3");
    step(1'b1, {9'd7, 5'b00011}, 32'h0000_005C, 4'h0, 1'b0, '0, "R3");
    step(1'b0, '0, '0, '0, 1'b1, {9'd7, 5'd17}, "R3");

    // Same-row read and write in one cycle, then the new contents
    step(1'b1, {9'd20, 5'd8}, 32'h0000_00C3, 4'h1, 1'b1, {9'd20, 5'd0}, "R8");
    step(1'b0, '0, '0, '0, 1'b1, {9'd20, 5'd31}, "R8");

    // Write while reads are disabled: outputs hold
    step(1'b1, {9'd20, 5'd16}, 32'h0000_003E, 4'h1, 1'b0, '0, "R7");
    step(1'b0, '0, '0, '0, 1'b0, {9'd30, 5'd0}, "R7");
    step(1'b0, '0, '0, '0, 1'b1, {9'd20, 5'd0}, "R6");

    // Random traffic with forced row collisions
    for (int i = 0; i < 8000; i++) begin
      logic [13:0] wa = 14'($urandom);
      logic [13:0] ra = 14'($urandom);
      if ($urandom % 4 == 0) ra = {wa[13:5], 5'($urandom)};
      step(1'($urandom), wa, $urandom, 4'($urandom), 1'($urandom), ra, "R6");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule